// File: doc/BRIEF.md
# I2S receiver with ping-pong sample buffer

This block turns an I2S serial audio stream into stereo samples and places them in a 32-word buffer. Software reads that buffer over a 32-bit Wishbone-style slave port. The buffer holds 16 stereo frames. It is filled as two halves of 8 frames each, and each half raises its own status bit when it completes. Software can therefore drain one half while the receiver fills the other.

The parameter `MASTER` picks the clocking mode for an instance:

- In master mode the block generates the bit clock and word select itself.
- In slave mode it takes both from outside and brings them, with the data line, into its clock domain through two-flop synchronizers.

In both modes the data bit is taken on the detected rising edge of the bit clock.

Each slot is cut down to a resolution chosen by software (16, 20 or 24 bits). Only the leading bits of the slot are kept, and they are stored right-justified in the buffer word.

Top module: `i2s_rx_buffered`

## Requirements
- R1: Reset and bus port.
  - Word offset 0 is an identity word: 0x1B1 when `MASTER`=1, 0x191 when `MASTER`=0.
  - `bus_ack` is a one-cycle pulse, one cycle after a request.
  - Buffer words (offsets 32..63) are read-only, and bus writes to them have no effect.
  - After reset the configuration, mask and status words read 0 and `irq` is low.
- R2: The left sample (word select low) of frame p is stored at offset 32+2p. The right sample (word select high) is stored at offset 33+2p. Successive frames go to successive values of p.
- R3: At resolution 24, the first 24 bits after the one-bit delay that follows a word-select change are stored right-justified. The remaining bits of the slot are dropped.
- R4: The configuration word (offset 1) carries a resolution code in bits 23:16. Code 16 keeps 16 bits, code 20 keeps 20 bits, and any other code keeps 24 bits. The kept bits are right-justified with zeros above them.
- R5: A sender that puts out 20 significant bits followed by zeros, received at resolution 24, yields the 20-bit value shifted left by 4.
- R6: In the status word (offset 3), bit 0 sets when the right sample of frame 7 is stored. Bit 1 sets when the right sample of frame 15 is stored.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R8: `irq` is high exactly when a status bit is set and its enable bit in the mask word (offset 2, bits 1:0) is also set. Each half has its own enable bit.
- R9: After frame 15 the write position wraps to frame 0 and keeps overwriting, even while status bits remain set.
- R10: Enable and reset of the write position.
  - Bit 0 of the configuration word enables reception, and the configuration word reads back as written in bits 23:16 and bit 0.
  - While the enable bit is clear, nothing is stored and the write position returns to frame 0.
  - After enable, storing begins with a left slot.
- R11: In master mode, `sck_out` has a period of 2*`HALF_DIV` clock cycles. `ws_out` changes only in the cycle where `sck_out` falls, and it changes once every 32 bit clocks.
- R12: In slave mode, `sck_in`, `ws_in` and `sd_in` are synchronized, and the same stream is captured as in master mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe for this slave |
| bus_we | input | 1 | Write when high |
| bus_adr | input | 6 | Word offset |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid with ack |
| bus_ack | output | 1 | Transfer acknowledge |
| irq | output | 1 | Masked half-buffer interrupt |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sd_in | input | 1 | Serial data |
| sck_out | output | 1 | Generated bit clock (master mode, else 0) |
| ws_out | output | 1 | Generated word select (master mode, else 0) |

## Verification
Each kind of internal fault shows up at the ports in its own way and within a bounded time:

- A bit counter that slips shows up as stored words shifted by one or more places, on the very next buffer read.
- A channel flag that is stuck or swapped puts the left tag byte in odd words.
- A write position that does not reset or does not wrap shows up within one half-fill (8 frames, about 4100 cycles). Either the status bits come in the wrong order, or frame 0 is not overwritten one full buffer period later.

The sender tags every slot with a frame number and a channel byte. Any misplaced word therefore breaks the run of frame numbers that the bench checks.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
    localparam int BUS_W     = 32;
    localparam int ADR_W     = 6;
    localparam int MAX_RES   = 24;
    localparam int SLOT_BITS = 32;
    localparam int FRAMES    = 16;
    localparam int PTR_W     = $clog2(FRAMES);
    localparam int BUF_AW    = PTR_W + 1;
    localparam int SLOT_W    = $clog2(SLOT_BITS);
    localparam int CNT_W     = SLOT_W + 1;

    typedef enum logic [1:0] {
        REG_IDENT  = 2'd0,
        REG_CONFIG = 2'd1,
        REG_MASK   = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] res_code;
        logic       enable;
    } cfg_t;

    typedef struct packed {
        logic               valid;
        logic               right;
        logic [MAX_RES-1:0] data;
    } sample_t;

    function automatic logic [BUS_W-1:0] ident_word(input bit master);
        return master ? 32'h0000_01B1 : 32'h0000_0191;
    endfunction

    function automatic logic [CNT_W-1:0] res_bits(input logic [7:0] code);
        case (code)
            8'd16:   return CNT_W'(16);
            8'd20:   return CNT_W'(20);
            default: return CNT_W'(24);
        endcase
    endfunction

    function automatic logic [MAX_RES-1:0] low_mask(input logic [CNT_W-1:0] n);
        logic [MAX_RES-1:0] m;
        for (int i = 0; i < MAX_RES; i++) m[i] = (i < int'(n));
        return m;
    endfunction
endpackage

// File: rtl/i2s_rx_clk.sv
module i2s_rx_clk
    import i2s_rx_pkg::*;
#(
    parameter int MASTER   = 1,
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic sck_out,
    output logic ws_out,
    output logic rise,
    output logic ws_s,
    output logic sd_s
);
    logic sck_q, ws_q;

    generate
        if (MASTER != 0) begin : g_master
            localparam int DIV_W = $clog2(HALF_DIV + 1);
            logic [DIV_W-1:0]  div_cnt;
            logic [SLOT_W-1:0] bit_cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    div_cnt <= '0;
                    bit_cnt <= '0;
                    sck_q   <= 1'b0;
                    ws_q    <= 1'b0;
                end else if (div_cnt == DIV_W'(HALF_DIV - 1)) begin
                    div_cnt <= '0;
                    sck_q   <= ~sck_q;
                    if (sck_q) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == SLOT_W'(SLOT_BITS - 1)) ws_q <= ~ws_q;
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end

            // R11: word select moves only together with a falling bit clock
            p_ws_on_fall_r11: assert property (@(posedge clk) disable iff (rst)
                (ws_q != $past(ws_q)) |-> ($past(sck_q) && !sck_q));
        end else begin : g_slave
            assign sck_q = 1'b0;
            assign ws_q  = 1'b0;
        end
    endgenerate

    logic       src_sck, src_ws;
    logic [2:0] sck_sy;
    logic [1:0] ws_sy, sd_sy;

    assign src_sck = (MASTER != 0) ? sck_q : sck_in;
    assign src_ws  = (MASTER != 0) ? ws_q  : ws_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sy <= '0;
            ws_sy  <= '0;
            sd_sy  <= '0;
        end else begin
            sck_sy <= {sck_sy[1:0], src_sck};
            ws_sy  <= {ws_sy[0], src_ws};
            sd_sy  <= {sd_sy[0], sd_in};
        end
    end

    assign rise    = sck_sy[1] & ~sck_sy[2];
    assign ws_s    = ws_sy[1];
    assign sd_s    = sd_sy[1];
    assign sck_out = sck_q;
    assign ws_out  = ws_q;
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2s_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic [7:0] res_code,
    input  logic       rise,
    input  logic       ws_s,
    input  logic       sd_s,
    output sample_t    smp
);
    logic               prev_ws, armed, chan;
    logic [CNT_W-1:0]   bit_cnt, res_n;
    logic [MAX_RES-1:0] shreg, shifted;

    assign res_n   = res_bits(res_code);
    assign shifted = {shreg[MAX_RES-2:0], sd_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ws <= 1'b0;
            armed   <= 1'b0;
            chan    <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            smp     <= '0;
        end else begin
            smp.valid <= 1'b0;
            if (!enable) armed <= 1'b0;
            if (rise) begin
                prev_ws <= ws_s;
                if (ws_s != prev_ws) begin
                    // this bit is the previous slot's LSB; the new slot starts next
                    bit_cnt <= '0;
                    chan    <= ws_s;
                    if (!ws_s && enable) armed <= 1'b1;
                end else if (bit_cnt < res_n) begin
                    shreg   <= shifted;
                    bit_cnt <= bit_cnt + 1'b1;
                    if ((bit_cnt == res_n - 1'b1) && armed && enable) begin
                        smp.valid <= 1'b1;
                        smp.right <= chan;
                        smp.data  <= shifted & low_mask(res_n);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2s_rx_bufctl.sv
module i2s_rx_bufctl
    import i2s_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  sample_t            smp,
    output logic               wr_en,
    output logic [BUF_AW-1:0]  wr_addr,
    output logic [MAX_RES-1:0] wr_data,
    output logic [1:0]         half_done
);
    logic [PTR_W-1:0] ptr;

    assign wr_en   = smp.valid & enable;
    assign wr_addr = {ptr, smp.right};
    assign wr_data = smp.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            half_done <= '0;
        end else begin
            half_done <= '0;
            if (!enable) begin
                ptr <= '0;
            end else if (smp.valid && smp.right) begin
                ptr <= ptr + 1'b1;
                if (ptr == PTR_W'(FRAMES / 2 - 1)) half_done[0] <= 1'b1;
                if (ptr == PTR_W'(FRAMES - 1))     half_done[1] <= 1'b1;
            end
        end
    end

    // R10: disabled reception parks the write position at frame 0
    p_ptr_park_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (ptr == '0));
    // R9: completing the last frame brings the position back to frame 0
    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (enable && smp.valid && smp.right && ptr == PTR_W'(FRAMES - 1)) |=> (ptr == '0));
endmodule

// File: rtl/i2s_rx_buffered.sv
module i2s_rx_buffered
    import i2s_rx_pkg::*;
#(
    parameter int MASTER   = 1,
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_cyc,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic [ADR_W-1:0] bus_adr,
    input  logic [BUS_W-1:0] bus_wdat,
    output logic [BUS_W-1:0] bus_rdat,
    output logic             bus_ack,
    output logic             irq,
    input  logic             sck_in,
    input  logic             ws_in,
    input  logic             sd_in,
    output logic             sck_out,
    output logic             ws_out
);
    localparam int WORDS = 2 * FRAMES;

    cfg_t               cfg;
    logic [1:0]         mask, status, half_done;
    logic               rise, ws_s, sd_s, wr_en;
    logic [BUF_AW-1:0]  wr_addr;
    logic [MAX_RES-1:0] wr_data;
    logic [MAX_RES-1:0] buf_mem [WORDS];
    sample_t            smp;
    logic               req, reg_wr, is_buf;
    logic [BUS_W-1:0]   rd_mux;

    i2s_rx_clk #(.MASTER(MASTER), .HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst(rst), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
        .sck_out(sck_out), .ws_out(ws_out), .rise(rise), .ws_s(ws_s), .sd_s(sd_s)
    );

    i2s_rx_deser u_deser (
        .clk(clk), .rst(rst), .enable(cfg.enable), .res_code(cfg.res_code),
        .rise(rise), .ws_s(ws_s), .sd_s(sd_s), .smp(smp)
    );

    i2s_rx_bufctl u_bufctl (
        .clk(clk), .rst(rst), .enable(cfg.enable), .smp(smp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .half_done(half_done)
    );

    always_ff @(posedge clk) begin
        if (wr_en) buf_mem[wr_addr] <= wr_data;
    end

    assign req    = bus_cyc & bus_stb & ~bus_ack;
    assign is_buf = bus_adr[ADR_W-1];
    assign reg_wr = req & bus_we & ~is_buf & (bus_adr[ADR_W-2:2] == '0);

    always_comb begin
        rd_mux = '0;
        if (is_buf) begin
            rd_mux = BUS_W'(buf_mem[bus_adr[BUF_AW-1:0]]);
        end else if (bus_adr[ADR_W-2:2] == '0) begin
            case (reg_sel_e'(bus_adr[1:0]))
                REG_IDENT:  rd_mux = ident_word(MASTER != 0);
                REG_CONFIG: rd_mux = {8'h00, cfg.res_code, 15'h0000, cfg.enable};
                REG_MASK:   rd_mux = {30'h0, mask};
                REG_STATUS: rd_mux = {30'h0, status};
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack  <= 1'b0;
            bus_rdat <= '0;
            cfg      <= '0;
            mask     <= '0;
            status   <= '0;
        end else begin
            bus_ack <= req;
            if (req && !bus_we) bus_rdat <= rd_mux;
            if (reg_wr && bus_adr[1:0] == REG_CONFIG)
                cfg <= '{res_code: bus_wdat[23:16], enable: bus_wdat[0]};
            if (reg_wr && bus_adr[1:0] == REG_MASK)
                mask <= bus_wdat[1:0];
            status <= (status & ~((reg_wr && bus_adr[1:0] == REG_STATUS) ? bus_wdat[1:0] : 2'b00))
                      | half_done;
        end
    end

    assign irq = |(status & mask);

    // R1: acknowledge is a single-cycle pulse
    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);
    // R6: a finished lower half shows up in status bit 0 on the next cycle
    p_half_set_r6: assert property (@(posedge clk) disable iff (rst)
        half_done[0] |=> status[0]);
    // R7: writing a one clears the bit unless a new completion coincides
    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && bus_adr[1:0] == REG_STATUS && bus_wdat[1] && !half_done[1]) |=> !status[1]);
endmodule

// File: tb/i2s_rx_buffered_test.sv
module i2s_rx_buffered_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, we = 1'b0, stb_m = 1'b0, stb_s = 1'b0;
    logic [5:0]  adr = '0;
    logic [31:0] wdat = '0;
    logic [31:0] rdat_m, rdat_s;
    logic        ack_m, ack_s, irq_m, irq_s;
    logic        msck, mws, s_sck, s_ws;
    logic        sd = 1'b0;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2s_rx_buffered #(.MASTER(1), .HALF_DIV(4)) uut (
        .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb_m), .bus_we(we),
        .bus_adr(adr), .bus_wdat(wdat), .bus_rdat(rdat_m), .bus_ack(ack_m),
        .irq(irq_m), .sck_in(1'b0), .ws_in(1'b0), .sd_in(sd),
        .sck_out(msck), .ws_out(mws)
    );

    i2s_rx_buffered #(.MASTER(0), .HALF_DIV(4)) uut_s (
        .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb_s), .bus_we(we),
        .bus_adr(adr), .bus_wdat(wdat), .bus_rdat(rdat_s), .bus_ack(ack_s),
        .irq(irq_s), .sck_in(msck), .ws_in(mws), .sd_in(sd),
        .sck_out(s_sck), .ws_out(s_ws)
    );

    // ---------------- serial sender model ----------------
    int         tx_bits = 32;
    logic [7:0] frame_n = 8'd0;

    function automatic logic [31:0] mkword(input logic [7:0] n, input bit ch, input int tb);
        logic [31:0] w;
        w = {n, (ch ? 8'hC3 : 8'h3C), 16'h9669};
        return w & (32'hFFFF_FFFF << (32 - tb));
    endfunction

    function automatic logic [31:0] expv(input logic [7:0] n, input bit ch, input int res, input int tb);
        return mkword(n, ch, tb) >> (32 - res);
    endfunction

    logic [31:0] cur_word = 32'h0;
    int          bit_idx = 0;
    logic        prev_sck = 1'b0, prev_ws = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            prev_sck = 1'b0;
            prev_ws  = 1'b0;
        end else begin
            if (prev_sck && !msck) begin
                if (mws != prev_ws) begin
                    sd = cur_word[0];
                    if (!mws) frame_n = frame_n + 8'd1;
                    cur_word = mkword(frame_n, mws, tx_bits);
                    bit_idx  = 0;
                end else begin
                    sd = cur_word[31 - bit_idx];
                    if (bit_idx < 31) bit_idx++;
                end
                prev_ws = mws;
            end
            prev_sck = msck;
        end
    end

    // ---------------- bus driver ----------------
    task automatic bus_xfer(input bit to_s, input bit wr, input logic [5:0] a,
                            input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        cyc = 1'b1; we = wr; adr = a; wdat = d;
        stb_m = !to_s; stb_s = to_s;
        do @(negedge clk); while (!(to_s ? ack_s : ack_m));
        q = to_s ? rdat_s : rdat_m;
        cyc = 1'b0; we = 1'b0; stb_m = 1'b0; stb_s = 1'b0;
    endtask

    task automatic rd(input bit to_s, input logic [5:0] a, output logic [31:0] q);
        bus_xfer(to_s, 1'b0, a, 32'h0, q);
    endtask

    task automatic wr(input bit to_s, input logic [5:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus_xfer(to_s, 1'b1, a, d, q);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_reg(input bit to_s, input logic [5:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] q;
        rd(to_s, a, q);
        check(tag, q, exp);
    endtask

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          to_s;
        logic [5:0]  a;
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic push_exp(input bit to_s, input logic [5:0] a, input logic [31:0] v, input string tag);
        exp_t e;
        e.to_s = to_s; e.a = a; e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) begin
            exp_t e;
            logic [31:0] q;
            e = exp_q.pop_front();
            rd(e.to_s, e.a, q);
            check(e.tag, q, e.v);
        end
    endtask

    task automatic check_half(input bit to_s, input int half, input int res, input int tb,
                              input string tag, output logic [7:0] n0);
        logic [31:0] q;
        int base;
        base = 32 + half * 16;
        rd(to_s, 6'(base), q);
        n0 = 8'(q >> (res - 8));
        for (int i = 0; i < 8; i++) begin
            for (int ch = 0; ch < 2; ch++) begin
                push_exp(to_s, 6'(base + 2 * i + ch), expv(n0 + 8'(i), ch[0], res, tb), tag);
            end
        end
        drain();
    endtask

    task automatic wait_irq(input bit to_s, input string tag);
        int k;
        k = 0;
        while (!(to_s ? irq_s : irq_m) && k < 20000) begin
            @(negedge clk);
            k++;
        end
        check({tag, " irq rises"}, 32'(to_s ? irq_s : irq_m), 32'd1);
    endtask

    task automatic measure_master();
        logic p_sck, p_ws;
        int rises, cyc_cnt, period;
        bit fell_with;
        @(negedge clk);
        p_sck = msck; p_ws = mws;
        while (mws == p_ws) begin
            p_sck = msck;
            @(negedge clk);
        end
        fell_with = p_sck && !msck;
        check("R11 ws changes with sck fall", 32'(fell_with), 32'd1);
        p_ws = mws; p_sck = msck;
        rises = 0; cyc_cnt = 0; period = -1;
        while (mws == p_ws) begin
            @(negedge clk);
            cyc_cnt++;
            if (msck && !p_sck) begin
                if (rises == 1) period = cyc_cnt;
                if (rises == 0) cyc_cnt = 0;
                rises++;
            end
            p_sck = msck;
        end
        check("R11 bit clocks per slot", 32'(rises), 32'd32);
        check("R11 sck period", 32'(period), 32'd8);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] q, a0;
        logic [7:0]  nm, nmu, ns, nsu, tmp;
        int k;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset and identity
        check_reg(0, 6'd0, 32'h1B1, "R1 master ident");
        check_reg(1, 6'd0, 32'h191, "R1 slave ident");
        check_reg(0, 6'd1, 32'h0, "R1 config reset");
        check_reg(0, 6'd2, 32'h0, "R1 mask reset");
        check_reg(0, 6'd3, 32'h0, "R1 status reset");
        check("R1 irq reset", 32'(irq_m), 32'd0);

        // R11 generated clocks
        measure_master();

        // phase 1: master 24-bit, slave 20-bit, full 32-bit sender
        wr(0, 6'd2, 32'h3);
        wr(1, 6'd2, 32'h2);
        wr(0, 6'd1, 32'h0018_0001);
        wr(1, 6'd1, 32'h0014_0001);
        check_reg(0, 6'd1, 32'h0018_0001, "R10 config readback");

        wait_irq(0, "R6 master lower");
        check_reg(0, 6'd3, 32'h1, "R6 lower half status");
        wr(0, 6'd3, 32'h2);
        check_reg(0, 6'd3, 32'h1, "R7 zero bits ignored");
        wr(0, 6'd3, 32'h1);
        check_reg(0, 6'd3, 32'h0, "R7 write one clears");
        check("R8 irq drops after clear", 32'(irq_m), 32'd0);
        check_half(0, 0, 24, 32, "R2 R3 master lower", nm);

        // slave lower half with only upper-half interrupt enabled
        k = 0;
        do begin
            rd(1, 6'd3, q);
            k++;
        end while (!q[0] && k < 4000);
        check("R6 slave lower status", q & 32'h1, 32'h1);
        check("R8 masked half keeps irq low", 32'(irq_s), 32'd0);
        check_half(1, 0, 20, 32, "R12 R4 slave lower", ns);

        // master upper half
        wait_irq(0, "R6 master upper");
        check_reg(0, 6'd3, 32'h2, "R6 upper half status");
        check_half(0, 1, 24, 32, "R2 master upper", nmu);
        check("R2 upper follows lower", 32'(nmu), 32'(nm + 8'd8));
        wr(0, 6'd3, 32'h2);

        // slave upper half and wrap with status left set
        wait_irq(1, "R8 slave upper");
        check_reg(1, 6'd3, 32'h3, "R9 both status bits held");
        check_half(1, 1, 20, 32, "R12 slave upper", nsu);
        check("R12 slave frames consecutive", 32'(nsu), 32'(ns + 8'd8));
        repeat (1100) @(negedge clk);
        check_reg(1, 6'd32, expv(ns + 8'd16, 1'b0, 20, 32), "R9 frame 0 overwritten");
        check_reg(1, 6'd3, 32'h3, "R9 status unchanged by wrap");

        // phase 2: disable, hold, read-only buffer, 20-bit sender into 24-bit
        wr(0, 6'd1, 32'h0);
        wr(0, 6'd3, 32'h3);
        rd(0, 6'd32, a0);
        wr(0, 6'd32, ~a0);
        check_reg(0, 6'd32, a0, "R1 buffer write ignored");
        repeat (1100) @(negedge clk);
        check_reg(0, 6'd32, a0, "R10 no store while disabled");
        check_reg(0, 6'd3, 32'h0, "R10 no status while disabled");
        tx_bits = 20;
        repeat (600) @(negedge clk);
        wr(0, 6'd1, 32'h0018_0001);
        wait_irq(0, "R10 restart");
        check_reg(0, 6'd3, 32'h1, "R10 restart from frame 0");
        check_half(0, 0, 24, 20, "R5 twenty into twenty-four", tmp);
        check_reg(0, 6'd32, 32'(mkword(tmp, 1'b0, 20) >> 12) << 4, "R5 shifted by four");

        // phase 3: 16-bit resolution
        wr(0, 6'd1, 32'h0);
        tx_bits = 32;
        repeat (1100) @(negedge clk);
        wr(0, 6'd3, 32'h3);
        wr(0, 6'd1, 32'h0010_0001);
        wait_irq(0, "R4 sixteen");
        check_half(0, 0, 16, 32, "R4 sixteen bit", tmp);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule